// File: doc/BRIEF.md
# UART Receive Byte Queue with Status

This block holds the bytes that a UART's receive path has recovered and hands them to a register bus. The serial side offers one byte per cycle, together with parity and framing error qualifiers, and can signal a line break. The bus side reads bytes from a data register, reads a status word holding the fill level, reads a sticky error register that clears itself when read, and writes a control register that enables the queue and can flush it.

With the queue disabled, a single holding register takes the place of the queue. The block raises two one-cycle event pulses: one for each byte it accepts and one for each error condition. Masking and routing of these pulses is left to the surrounding logic.

The receive stream uses valid/ready with no stall. A deserializer cannot hold a byte back, so `rx_ready` is advisory. It is low only when the queue is enabled and full. A byte offered while `rx_ready` is low is discarded and counted as an overrun. In holding mode `rx_ready` is always high, and a new byte overwrites the held one.

Top module: `uart_rx_queue`

## Requirements
- R1: Bus register map by `bus_addr`: 0 = control (bit 0 queue enable, bit 1 flush), 1 = status, 2 = error status, 3 = receive data. The status word carries the fill count in bits [7:0], a full flag in bit 8, and in bit 9 a flag that is set while any error-status bit is set.
- R2: When the queue holds DEPTH bytes, status bit 8 is 1 and the count field reads 0.
- R3: Writing control with bit 1 set empties the queue in that cycle. Control bit 1 always reads 0, and control bit 0 reads back the enable last written.
- R4: With the queue enabled and full, `rx_ready` is 0. A byte offered then is dropped, the stored bytes are kept, error bit 0 (overrun) is set and `evt_err` pulses.
- R5: Reading the data register with the queue enabled and empty returns 0 and pulses `evt_err`.
- R6: In queue mode, `data_ready` is 1 while bytes remain and falls when the last byte is read.
- R7: `rx_break` stores a 0x00 byte, sets error bit 3 (break) and pulses `evt_err`. A byte offered in the same cycle is discarded.
- R8: The error-status register (bit 0 overrun, bit 1 parity, bit 2 framing, bit 3 break) clears when read. Errors arriving in the cycle of that read are kept.
- R9: With the queue disabled, a received byte loads the holding register and sets `data_ready`. Reading the data register returns it and clears `data_ready`. A second byte that arrives before the read overwrites the first and sets the overrun bit.
- R10: Bytes leave in arrival order. `evt_rx` pulses once per accepted byte, but not for break bytes. `rx_par_err` or `rx_frm_err` with a valid byte sets error bit 1 or bit 2 and pulses `evt_err`.
- R11: A byte accepted and a byte read in the same cycle leave the count unchanged.
- R12: After reset the queue is empty, queue mode is off, the error register is 0 and no event is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | A received byte is offered |
| rx_ready | output | 1 | Space available (advisory, no stall) |
| rx_data | input | DW | Received byte |
| rx_par_err | input | 1 | Parity error on the offered byte |
| rx_frm_err | input | 1 | Framing error on the offered byte |
| rx_break | input | 1 | Line break detected (one-cycle pulse) |
| bus_rd | input | 1 | Read strobe; side effects happen at the clock edge |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 2 | Control write field |
| bus_rdata | output | BW | Read data for `bus_addr`, combinational |
| data_ready | output | 1 | Received data available |
| evt_rx | output | 1 | Byte accepted pulse |
| evt_err | output | 1 | Error condition pulse |

## Verification
The assertions check on every cycle the relations that hold locally:
- a full queue shows a zero count;
- a flush leaves no data ready;
- a refused byte or a read of an empty queue is followed by an error pulse;
- a break sets its bit;
- a quiet error read leaves the register clear;
- a simultaneous accept and read keep the count.

Other behaviour needs the scenarios in the bench, because it depends on a history of pushes and reads:
- byte order through the queue;
- overwriting in holding mode;
- the null byte left by a break;
- errors that survive a clearing read in the same cycle.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_STAT = 2'd1,
    RA_ERR  = 2'd2,
    RA_DATA = 2'd3
  } rxf_addr_e;

  localparam int NERR    = 4;
  localparam int EB_OVR  = 0;
  localparam int EB_PAR  = 1;
  localparam int EB_FRM  = 2;
  localparam int EB_BRK  = 3;

  localparam int CB_EN   = 0;
  localparam int CB_CLR  = 1;

  localparam int CNT_W   = 8;
  localparam int SB_FULL = 8;
  localparam int SB_ERR  = 9;
endpackage

// File: rtl/rxf_queue.sv
module rxf_queue #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     push,
  input  logic                     pop,
  input  logic [W-1:0]             din,
  output logic [W-1:0]             dout,
  output logic [$clog2(DEPTH):0]   count,
  output logic                     full,
  output logic                     empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp;

  // the extra top bit of each pointer separates full from empty
  assign count = wp - rp;
  assign empty = (wp == rp);
  assign full  = (count == (AW+1)'(DEPTH));
  assign dout  = mem[rp[AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else if (clr) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push && !full) wp <= wp + 1'b1;
      if (pop && !empty) rp <= rp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full && !clr) mem[wp[AW-1:0]] <= din;
  end
endmodule

// File: rtl/rxf_errlog.sv
module rxf_errlog #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         rd_clr,
  output logic [N-1:0] err_q
);
  // a read clears the old bits, and new bits from the same cycle survive
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= (rd_clr ? '0 : err_q) | set;
  end
endmodule

// File: rtl/rxf_hold.sv
module rxf_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         take,
  output logic [W-1:0] hold_q,
  output logic         hfull
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      hfull  <= 1'b0;
    end else if (load) begin
      hold_q <= din;
      hfull  <= 1'b1;
    end else if (take) begin
      hfull  <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
  import rxf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int BW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_par_err,
  input  logic          rx_frm_err,
  input  logic          rx_break,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [1:0]    bus_wdata,
  output logic [BW-1:0] bus_rdata,
  output logic          data_ready,
  output logic          evt_rx,
  output logic          evt_err
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  rxf_addr_e      sel;
  logic           en_q;
  logic           rd_data, rd_err, ctl_wr, clr;
  logic           offer;
  logic [DW-1:0]  byte_in;
  logic           q_push, q_pop, q_full, q_empty;
  logic [DW-1:0]  q_dout;
  logic [CW-1:0]  q_count;
  logic           drop, hold_over, underflow;
  logic [NERR-1:0] err_set, err_q;
  logic [DW-1:0]  hold_q;
  logic           hfull;
  logic           evt_rx_d, evt_err_d;
  logic [CNT_W-1:0] cnt_field;

  assign sel     = rxf_addr_e'(bus_addr);
  assign rd_data = bus_rd && !bus_wr && (sel == RA_DATA);
  assign rd_err  = bus_rd && !bus_wr && (sel == RA_ERR);
  assign ctl_wr  = bus_wr && (sel == RA_CTRL);
  assign clr     = ctl_wr && bus_wdata[CB_CLR];

  // a break takes the slot and stands in for a null byte
  assign offer   = rx_valid || rx_break;
  assign byte_in = rx_break ? '0 : rx_data;

  assign q_push    = en_q && offer && !q_full && !clr;
  assign q_pop     = en_q && rd_data && !q_empty;
  assign drop      = en_q && offer && q_full;
  assign hold_over = !en_q && offer && hfull && !rd_data;
  assign underflow = en_q && rd_data && q_empty;

  always_comb begin
    err_set         = '0;
    err_set[EB_OVR] = drop || hold_over;
    err_set[EB_PAR] = rx_valid && !rx_break && rx_par_err;
    err_set[EB_FRM] = rx_valid && !rx_break && rx_frm_err;
    err_set[EB_BRK] = rx_break;
  end

  assign evt_err_d = (|err_set) || underflow;
  assign evt_rx_d  = rx_valid && !rx_break &&
                     (!en_q || (!q_full && !clr));

  rxf_queue #(.DEPTH(DEPTH), .W(DW)) u_queue (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .push  (q_push),
    .pop   (q_pop),
    .din   (byte_in),
    .dout  (q_dout),
    .count (q_count),
    .full  (q_full),
    .empty (q_empty)
  );

  rxf_errlog #(.N(NERR)) u_errlog (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (err_set),
    .rd_clr (rd_err),
    .err_q  (err_q)
  );

  rxf_hold #(.W(DW)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (!en_q && offer),
    .din    (byte_in),
    .take   (!en_q && rd_data),
    .hold_q (hold_q),
    .hfull  (hfull)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      evt_rx  <= 1'b0;
      evt_err <= 1'b0;
    end else begin
      if (ctl_wr) en_q <= bus_wdata[CB_EN];
      evt_rx  <= evt_rx_d;
      evt_err <= evt_err_d;
    end
  end

  assign rx_ready   = en_q ? !q_full : 1'b1;
  assign data_ready = en_q ? !q_empty : hfull;

  // a full queue shows a zero count next to the full flag
  assign cnt_field = q_full ? '0 : CNT_W'(q_count);

  always_comb begin
    bus_rdata = '0;
    unique case (sel)
      RA_CTRL: bus_rdata[CB_EN] = en_q;
      RA_STAT: begin
        bus_rdata[CNT_W-1:0] = cnt_field;
        bus_rdata[SB_FULL]   = q_full;
        bus_rdata[SB_ERR]    = |err_q;
      end
      RA_ERR:  bus_rdata[NERR-1:0] = err_q;
      RA_DATA: bus_rdata[DW-1:0]   = en_q ? (q_empty ? '0 : q_dout) : hold_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rxf_chk.sv
module rxf_chk #(
  parameter int CW = 5,
  parameter int BW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic          rx_break,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [1:0]    bus_addr,
  input logic [1:0]    bus_wdata,
  input logic [BW-1:0] bus_rdata,
  input logic          data_ready,
  input logic          evt_err,
  input logic          en_q,
  input logic [CW-1:0] q_count,
  input logic          q_push,
  input logic          q_pop,
  input logic [3:0]    err_q
);
  AST_FULL_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd1 && bus_rdata[8]) |-> (bus_rdata[7:0] == 8'd0)); // R2

  AST_CTRL_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd0) |-> (bus_rdata[1] == 1'b0)); // R3

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0 && bus_wdata == 2'b11) |=> !data_ready); // R3

  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> evt_err); // R4

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && bus_rd && !bus_wr && bus_addr == 2'd3 && !data_ready)
      |-> (bus_rdata == '0)); // R5

  AST_EMPTY_READ_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && bus_rd && !bus_wr && bus_addr == 2'd3 && !data_ready) |=> evt_err); // R5

  AST_BREAK_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_break |=> err_q[3]); // R7

  AST_ERR_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr == 2'd2 && !rx_valid && !rx_break)
      |=> (err_q == 4'd0)); // R8

  AST_HOLD_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !bus_wr && bus_rd && bus_addr == 2'd3 && !rx_valid && !rx_break)
      |=> !data_ready); // R9

  AST_PUSH_POP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (q_push && q_pop) |=> (q_count == $past(q_count))); // R11
endmodule

bind uart_rx_queue rxf_chk #(.CW(CW), .BW(BW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_valid   (rx_valid),
  .rx_ready   (rx_ready),
  .rx_break   (rx_break),
  .bus_rd     (bus_rd),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .data_ready (data_ready),
  .evt_err    (evt_err),
  .en_q       (en_q),
  .q_count    (q_count),
  .q_push     (q_push),
  .q_pop      (q_pop),
  .err_q      (err_q)
);

// File: tb/sim_uart_rx_queue.sv
`timescale 1ns/1ps
module sim_uart_rx_queue;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_valid, rx_par_err, rx_frm_err, rx_break;
  logic [7:0]  rx_data;
  logic        bus_rd, bus_wr;
  logic [1:0]  bus_addr, bus_wdata;
  logic [31:0] bus_rdata;
  logic        rx_ready, data_ready, evt_rx, evt_err;

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  logic [7:0] q [$];
  bit         en_m = 0;
  logic [7:0] hold_m = 8'h00;
  bit         hfull_m = 0;
  logic [3:0] err_m = 4'h0;
  bit         exp_evt_rx = 0, exp_evt_err = 0;

  always #4 clk = ~clk;

  uart_rx_queue #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .rx_break(rx_break),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .data_ready(data_ready), .evt_rx(evt_rx), .evt_err(evt_err)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic idle_in();
    rx_valid = 0; rx_data = 8'h00; rx_par_err = 0; rx_frm_err = 0; rx_break = 0;
    bus_rd = 0; bus_wr = 0; bus_addr = 2'd1; bus_wdata = 2'd0;
  endtask

  function automatic logic [31:0] exp_rdata();
    logic [31:0] r = '0;
    int sz = q.size();
    case (bus_addr)
      2'd0: r[0] = en_m;
      2'd1: begin
        r[7:0] = (sz == DEPTH) ? 8'd0 : 8'(sz);
        r[8]   = (sz == DEPTH);
        r[9]   = (err_m != 0);
      end
      2'd2: r[3:0] = err_m;
      default: r[7:0] = en_m ? ((sz > 0) ? q[0] : 8'h00) : hold_m;
    endcase
    return r;
  endfunction

  task automatic model_step();
    int  sz = q.size();
    bit  rdd = bus_rd && !bus_wr && bus_addr == 2'd3;
    bit  rde = bus_rd && !bus_wr && bus_addr == 2'd2;
    bit  cw  = bus_wr && bus_addr == 2'd0;
    bit  clr = cw && bus_wdata[1];
    bit  offer = rx_valid || rx_break;
    logic [7:0] b = rx_break ? 8'h00 : rx_data;
    logic [3:0] ns = 4'h0;
    bit  er = 0, erx = 0;
    if (en_m) begin
      if (rdd) begin
        if (sz > 0) void'(q.pop_front());
        else er = 1;
      end
      if (offer) begin
        if (sz < DEPTH) begin
          if (!clr) begin q.push_back(b); erx = !rx_break; end
        end else ns[0] = 1;
      end
      if (clr) q.delete();
    end else begin
      if (offer) begin
        if (hfull_m && !rdd) ns[0] = 1;
        hold_m = b; hfull_m = 1; erx = !rx_break;
      end else if (rdd) hfull_m = 0;
    end
    if (rx_valid && !rx_break && rx_par_err) ns[1] = 1;
    if (rx_valid && !rx_break && rx_frm_err) ns[2] = 1;
    if (rx_break) ns[3] = 1;
    if (ns != 0) er = 1;
    err_m = (rde ? 4'h0 : err_m) | ns;
    if (cw) en_m = bus_wdata[0];
    exp_evt_rx = erx;
    exp_evt_err = er;
  endtask

  // compare every output, clock once, advance the model
  task automatic step(input string tag);
    #1;
    chk(tag, "rx_ready", 32'(rx_ready), 32'(en_m ? (q.size() < DEPTH) : 1'b1));
    chk(tag, "data_ready", 32'(data_ready), 32'(en_m ? (q.size() > 0) : hfull_m));
    chk(tag, "evt_rx", 32'(evt_rx), 32'(exp_evt_rx));
    chk(tag, "evt_err", 32'(evt_err), 32'(exp_evt_err));
    chk(tag, "bus_rdata", bus_rdata, exp_rdata());
    @(posedge clk);
    model_step();
    @(negedge clk);
    idle_in();
  endtask

  task automatic push(input logic [7:0] b, input string tag);
    rx_valid = 1; rx_data = b; step(tag);
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    bus_rd = 1; bus_addr = a; step(tag);
  endtask

  task automatic wr(input logic [1:0] a, input logic [1:0] d, input string tag);
    bus_wr = 1; bus_addr = a; bus_wdata = d; step(tag);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle_in();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R12: reset state
    step("R12"); rd(2'd0, "R12"); rd(2'd2, "R12");
    // R9: holding register mode
    push(8'h41, "R9"); rd(2'd3, "R9"); step("R9");
    push(8'h42, "R9"); push(8'h43, "R9"); rd(2'd3, "R9");
    rd(2'd2, "R8"); step("R8");
    // R3: enable the queue
    wr(2'd0, 2'd1, "R3"); rd(2'd0, "R3");
    // R10: order, events and line error bits
    push(8'h11, "R10");
    rx_par_err = 1; push(8'h22, "R10");
    rx_frm_err = 1; push(8'h33, "R10");
    rd(2'd1, "R1"); rd(2'd2, "R10");
    rd(2'd3, "R6"); rd(2'd3, "R6"); rd(2'd3, "R6"); step("R6");
    // R5: read of empty queue
    rd(2'd3, "R5"); step("R5");
    rx_valid = 1; rx_data = 8'h5A; bus_rd = 1; bus_addr = 2'd3; step("R5");
    rd(2'd3, "R5");
    // R2 / R4: fill, then overflow
    for (int i = 0; i < DEPTH; i++) push(8'(8'h80 + i), "R2");
    rd(2'd1, "R2");
    push(8'hEE, "R4"); rd(2'd1, "R4"); rd(2'd2, "R4"); rd(2'd3, "R4");
    // R11: accept and read together
    rx_valid = 1; rx_data = 8'h55; bus_rd = 1; bus_addr = 2'd3; step("R11");
    rd(2'd1, "R11");
    rx_valid = 1; rx_data = 8'h66; bus_rd = 1; bus_addr = 2'd3; step("R11");
    rd(2'd1, "R11");
    // R3: flush keeps enable
    wr(2'd0, 2'd3, "R3"); rd(2'd0, "R3"); rd(2'd1, "R3");
    // R7: break pushes null
    rx_break = 1; step("R7");
    rx_break = 1; rx_valid = 1; rx_data = 8'h99; step("R7");
    rd(2'd1, "R7"); rd(2'd3, "R7"); rd(2'd3, "R7"); rd(2'd2, "R7");
    // R8: error arriving during clearing read survives
    rx_par_err = 1; rx_valid = 1; rx_data = 8'h77; bus_rd = 1; bus_addr = 2'd2; step("R8");
    rd(2'd2, "R8"); rd(2'd2, "R8");
    // back to holding mode
    wr(2'd0, 2'd0, "R9"); push(8'hA5, "R9"); rd(2'd3, "R9"); step("R9");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule